// File: doc/BRIEF.md
# RMII Receive to MII Receive Bridge

This block sits between a reduced-pin PHY and a MAC receive port. On the 50 MHz reference clock it samples the two-bit receive data and the shared carrier/data-valid line, locks onto the start-of-frame delimiter, pairs dibits into nibbles and hands them to a 25 MHz MII receive clock domain. It separates the shared line into a carrier-sense output and a data-valid output. It recognises the toggling pattern that the PHY uses to flush elastic nibbles at frame end, produces the MII false-carrier code, and carries the PHY receive error through to the nibble it belongs to.

Two line rates are supported. With `rate100` high every reference clock carries a dibit. With it low one dibit is taken every tenth reference clock, and each nibble is held for ten MII clocks. A small dual-clock buffer moves typed entries (data nibble, end of frame, false carrier) between the domains. The read side waits for two entries before it opens a frame, so the MII stream has no gaps.

Top module: `rmii_rx_bridge`

## Requirements
- R1: While reset is held and right after it is released, `miiRxDv`, `miiRxErr`, `miiRxd` and `miiCrs` are all 0.
- R2: No nibble reaches the MII side before the delimiter byte 0xD5 has been received. Dibits arrive least-significant first, so the delimiter is seen as 01, 01, 01, 11. Preamble dibits are never forwarded, and a carrier that ends before the delimiter produces no MII output.
- R3: Each MII nibble holds the first-received dibit of its pair in bits [1:0] and the second in bits [3:2].
- R4: With `rate100` = 0 the shared line and the data are sampled once every ten reference clocks, and each nibble is shown with `miiRxDv` = 1 for exactly ten consecutive MII clocks. With `rate100` = 1 each nibble is shown for one MII clock.
- R5: If two consecutive dibits of value 10 (binary) arrive before the delimiter, the activity is a false carrier. Once the shared line is sampled low, the MII side shows `miiRxErr` = 1, `miiRxDv` = 0 and `miiRxd` = 0xE for one nibble slot, and no data-valid is raised. A single isolated 10 dibit does not trigger this.
- R6: If `rmiiRxErr` is high on either dibit of a nibble, `miiRxErr` is 1 while that nibble is shown. Otherwise it is 0.
- R7: When the shared line is low on first-dibit slots and high on second-dibit slots at frame end, those trailing nibbles are still delivered. `miiRxDv` stays high as one unbroken run per frame.
- R8: `miiCrs` falls in the reference-clock cycle after the shared line is first sampled low in a frame. This happens before the frame's final nibbles appear on the MII side.
- R9: Data valid ends only after the shared line is low on both dibit slots of one nibble position. Exactly the payload nibbles are delivered, with none extra.
- R10: `miiCrs` rises in the reference-clock cycle after the shared line is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | 50 MHz reference clock of the reduced interface |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| rate100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps; changed only between frames |
| rmiiCrsDv | input | 1 | Shared carrier-sense / data-valid line from the PHY |
| rmiiRxd | input | 2 | Receive dibit from the PHY |
| rmiiRxErr | input | 1 | Receive error from the PHY |
| miiRxClk | input | 1 | 25 MHz MII receive clock |
| miiRxd | output | 4 | Receive nibble to the MAC |
| miiRxDv | output | 1 | Receive data valid to the MAC |
| miiRxErr | output | 1 | Receive error to the MAC, also used in the false-carrier code |
| miiCrs | output | 1 | Carrier sense, registered on `refClk` |

## Verification
Carrier sense is a reference-clock result. It is due one edge after the sampling slot, so the bench reads it at the end of the dibit that moved it: one reference clock at 100 Mbps, ten at 10 Mbps. Nibbles, errors and the false-carrier code cross the buffer with a latency of a few MII clocks that depends on clock phase. The bench therefore logs every MII clock with data valid, plus each false-carrier cycle, and compares the whole log with the expected stream after a drain of forty dibit times. At 10 Mbps the expected stream repeats each nibble ten times. Counts of data-valid runs and flagged errors are checked alongside the data.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {K_DATA = 2'd0, K_END = 2'd1, K_FALSE = 2'd2} entryKind_e;

  typedef struct packed {
    entryKind_e kind;
    logic       err;
    logic [3:0] nib;
  } rxEntry_t;

  typedef struct packed {
    logic shiftEn;
    logic clearSr;
    logic storeLow;
    logic pushData;
    logic pushEnd;
    logic pushFalse;
  } rxStrobes_t;

  localparam int         ENTRY_W   = $bits(rxEntry_t);
  localparam logic [7:0] SFD_BYTE  = 8'hD5;
  localparam logic [1:0] BAD_DIBIT = 2'b10;
  localparam logic [3:0] FALSE_NIB = 4'hE;
endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       rate100,
  input  logic       crsDv,
  input  logic       sfdHit,
  input  logic       isBad,
  output rxStrobes_t strb,
  output logic       miiCrs
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_FALSE} state_e;

  state_e           state, stateNx;
  logic [DIV_W-1:0] divCnt;
  logic             slot;
  logic             phase, phaseNx;
  logic             firstLow, firstLowNx;
  logic             badRun, badRunNx;
  logic             crsNx;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (rate100 || divCnt == DIV_W'(SLOW_DIV - 1)) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign slot = (divCnt == '0);

  always_comb begin
    stateNx    = state;
    phaseNx    = phase;
    firstLowNx = firstLow;
    badRunNx   = badRun;
    crsNx      = miiCrs;
    strb       = '0;
    if (slot) begin
      unique case (state)
        S_IDLE: begin
          crsNx = crsDv;
          if (crsDv) begin
            strb.shiftEn = 1'b1;
            badRunNx     = isBad;
            stateNx      = S_PRE;
          end
        end
        S_PRE: begin
          if (!crsDv) begin
            crsNx        = 1'b0;
            strb.clearSr = 1'b1;
            stateNx      = S_IDLE;
          end else if (isBad && badRun) begin
            strb.clearSr = 1'b1;
            stateNx      = S_FALSE;
          end else if (sfdHit) begin
            strb.clearSr = 1'b1;
            phaseNx      = 1'b0;
            stateNx      = S_DATA;
          end else begin
            strb.shiftEn = 1'b1;
            badRunNx     = isBad;
          end
        end
        S_DATA: begin
          if (!crsDv) crsNx = 1'b0;
          if (!phase) begin
            strb.storeLow = 1'b1;
            firstLowNx    = !crsDv;
            phaseNx       = 1'b1;
          end else begin
            phaseNx = 1'b0;
            if (firstLow && !crsDv) begin
              strb.pushEnd = 1'b1;
              stateNx      = S_IDLE;
            end else begin
              strb.pushData = 1'b1;
            end
          end
        end
        S_FALSE: begin
          if (!crsDv) begin
            crsNx          = 1'b0;
            strb.pushFalse = 1'b1;
            stateNx        = S_IDLE;
          end
        end
        default: stateNx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= 1'b0;
      firstLow <= 1'b0;
      badRun   <= 1'b0;
      miiCrs   <= 1'b0;
    end else begin
      state    <= stateNx;
      phase    <= phaseNx;
      firstLow <= firstLowNx;
      badRun   <= badRunNx;
      miiCrs   <= crsNx;
    end
  end

  // R8
  crs_drop_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(miiCrs) |-> $past(!crsDv && slot));

  // R2
  sfd_entry_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (state == S_DATA && $past(state) != S_DATA) |-> $past(sfdHit && slot));
endmodule

// File: rtl/rmii_rx_datapath.sv
module rmii_rx_datapath
  import rmii_rx_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic [1:0] rxd,
  input  logic       rxErr,
  input  rxStrobes_t strb,
  output logic       sfdHit,
  output logic       isBad,
  output logic       wrEn,
  output rxEntry_t   wrEntry
);
  logic [7:0] shiftReg;
  logic [1:0] lowQ;
  logic       errQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lowQ     <= '0;
      errQ     <= 1'b0;
    end else begin
      if (strb.clearSr) shiftReg <= '0;
      else if (strb.shiftEn) shiftReg <= {rxd, shiftReg[7:2]};
      if (strb.storeLow) begin
        lowQ <= rxd;
        errQ <= rxErr;
      end
    end
  end

  assign sfdHit = ({rxd, shiftReg[7:2]} == SFD_BYTE);
  assign isBad  = (rxd == BAD_DIBIT);
  assign wrEn   = strb.pushData | strb.pushEnd | strb.pushFalse;

  always_comb begin
    wrEntry = '{kind: K_END, err: 1'b0, nib: 4'h0};
    if (strb.pushData) wrEntry = '{kind: K_DATA, err: errQ | rxErr, nib: {rxd, lowQ}};
    else if (strb.pushFalse) wrEntry = '{kind: K_FALSE, err: 1'b1, nib: FALSE_NIB};
  end
endmodule

// File: rtl/rmii_rx_cdc_fifo.sv
module rmii_rx_cdc_fifo #(
  parameter int WIDTH      = 7,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [WIDTH-1:0]      wrData,
  input  logic                  rdEn,
  output logic [WIDTH-1:0]      rdData,
  output logic [DEPTH_LOG2:0]   rdLevel
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PW    = DEPTH_LOG2 + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0]    rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic             full;

  assign full = ((wrBin - fromGray(rdGrayS2)) == PW'(DEPTH));

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrEn && !full) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && !full) mem[wrBin[DEPTH_LOG2-1:0]] <= wrData;
  end

  assign rdLevel = fromGray(wrGrayS2) - rdBin;
  assign rdData  = mem[rdBin[DEPTH_LOG2-1:0]];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (rdEn && rdLevel != '0) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    wrEn |-> !full);
endmodule

// File: rtl/rmii_rx_mii_out.sv
module rmii_rx_mii_out
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10,
  parameter int LVL_W    = 4
) (
  input  logic             miiRxClk,
  input  logic             rstN,
  input  logic             rate100,
  input  rxEntry_t         head,
  input  logic [LVL_W-1:0] level,
  output logic             rdEn,
  output logic [3:0]       miiRxd,
  output logic             miiRxDv,
  output logic             miiRxErr
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             slot, active, startOk;

  always_ff @(posedge miiRxClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (rate100 || divCnt == DIV_W'(SLOW_DIV - 1)) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign slot    = (divCnt == '0);
  assign startOk = (level >= LVL_W'(2)) || (level != '0 && head.kind != K_DATA);
  assign rdEn    = slot && (level != '0) && (active || startOk);

  always_ff @(posedge miiRxClk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      miiRxd   <= '0;
      miiRxDv  <= 1'b0;
      miiRxErr <= 1'b0;
    end else if (slot) begin
      if (rdEn) begin
        unique case (head.kind)
          K_DATA: begin
            miiRxDv  <= 1'b1;
            miiRxd   <= head.nib;
            miiRxErr <= head.err;
            active   <= 1'b1;
          end
          K_FALSE: begin
            miiRxDv  <= 1'b0;
            miiRxd   <= head.nib;
            miiRxErr <= head.err;
            active   <= 1'b0;
          end
          default: begin
            miiRxDv  <= 1'b0;
            miiRxd   <= '0;
            miiRxErr <= 1'b0;
            active   <= 1'b0;
          end
        endcase
      end else begin
        miiRxDv  <= 1'b0;
        miiRxd   <= '0;
        miiRxErr <= 1'b0;
      end
    end
  end

  // R5
  false_code_chk: assert property (@(posedge miiRxClk) disable iff (!rstN)
    (!miiRxDv && miiRxErr) |-> (miiRxd == FALSE_NIB));

  // R4
  slow_hold_chk: assert property (@(posedge miiRxClk) disable iff (!rstN)
    (!rate100 && divCnt > DIV_W'(1)) |-> ($stable(miiRxDv) && $stable(miiRxd)));
endmodule

// File: rtl/rmii_rx_bridge.sv
module rmii_rx_bridge
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV        = 10,
  parameter int FIFO_DEPTH_LOG2 = 3
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       rate100,
  input  logic       rmiiCrsDv,
  input  logic [1:0] rmiiRxd,
  input  logic       rmiiRxErr,
  input  logic       miiRxClk,
  output logic [3:0] miiRxd,
  output logic       miiRxDv,
  output logic       miiRxErr,
  output logic       miiCrs
);
  localparam int LVL_W = FIFO_DEPTH_LOG2 + 1;

  rxStrobes_t         strb;
  rxEntry_t           wrEntry, head;
  logic               sfdHit, isBad, wrEn, rdEn;
  logic [ENTRY_W-1:0] rdRaw;
  logic [LVL_W-1:0]   level;

  rmii_rx_ctrl #(.SLOW_DIV(SLOW_DIV)) i_ctrl (
    .refClk(refClk), .rstN(rstN), .rate100(rate100), .crsDv(rmiiCrsDv),
    .sfdHit(sfdHit), .isBad(isBad), .strb(strb), .miiCrs(miiCrs)
  );

  rmii_rx_datapath i_datapath (
    .refClk(refClk), .rstN(rstN), .rxd(rmiiRxd), .rxErr(rmiiRxErr), .strb(strb),
    .sfdHit(sfdHit), .isBad(isBad), .wrEn(wrEn), .wrEntry(wrEntry)
  );

  rmii_rx_cdc_fifo #(.WIDTH(ENTRY_W), .DEPTH_LOG2(FIFO_DEPTH_LOG2)) i_fifo (
    .wrClk(refClk), .rdClk(miiRxClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrEntry),
    .rdEn(rdEn), .rdData(rdRaw), .rdLevel(level)
  );

  assign head = rxEntry_t'(rdRaw);

  rmii_rx_mii_out #(.SLOW_DIV(SLOW_DIV), .LVL_W(LVL_W)) i_out (
    .miiRxClk(miiRxClk), .rstN(rstN), .rate100(rate100), .head(head), .level(level),
    .rdEn(rdEn), .miiRxd(miiRxd), .miiRxDv(miiRxDv), .miiRxErr(miiRxErr)
  );
endmodule

// File: tb/test_rmii_rx_bridge.sv
module test_rmii_rx_bridge;
  logic       refClk = 1'b0, miiRxClk = 1'b0, rstN = 1'b0, rate100 = 1'b1;
  logic       crsDv = 1'b0, rxErr = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [3:0] miiRxd;
  logic       miiRxDv, miiRxErr, miiCrs;

  int checkCnt = 0, failCnt = 0, fcCycles = 0, dvRises = 0, rep = 1;
  logic prevDv = 1'b0;
  logic [4:0] obsQ[$];
  logic [4:0] expQ[$];

  rmii_rx_bridge i_rmii_rx_bridge (
    .refClk(refClk), .rstN(rstN), .rate100(rate100), .rmiiCrsDv(crsDv),
    .rmiiRxd(rxd), .rmiiRxErr(rxErr), .miiRxClk(miiRxClk),
    .miiRxd(miiRxd), .miiRxDv(miiRxDv), .miiRxErr(miiRxErr), .miiCrs(miiCrs)
  );

  always #10 refClk = ~refClk;
  initial begin
    #13;
    forever #20 miiRxClk = ~miiRxClk;
  end

  always @(negedge miiRxClk) begin
    if (rstN) begin
      if (miiRxDv) obsQ.push_back({miiRxErr, miiRxd});
      if (!miiRxDv && miiRxErr && miiRxd == 4'hE) fcCycles++;
      if (miiRxDv && !prevDv) dvRises++;
      prevDv = miiRxDv;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic putDibit(input logic [1:0] d, input logic line, input logic e);
    rxd = d; crsDv = line; rxErr = e;
    repeat (rep) @(negedge refClk);
  endtask

  task automatic clearObs();
    obsQ.delete(); expQ.delete(); fcCycles = 0; dvRises = 0;
  endtask

  function automatic int countErr(input bit useObs);
    int n = 0;
    if (useObs) begin foreach (obsQ[i]) if (obsQ[i][4]) n++; end
    else begin foreach (expQ[i]) if (expQ[i][4]) n++; end
    return n;
  endfunction

  task automatic sendFrame(input int preLen, input int nNib, input int tail,
                           input int errIdx, input bit firstBad);
    logic [3:0] nib;
    int bad;
    clearObs();
    putDibit(firstBad ? 2'b10 : 2'b01, 1'b1, 1'b0);
    check(miiCrs == 1'b1, "R10 carrier sense rise", miiCrs, 1);
    repeat (preLen) putDibit(2'b01, 1'b1, 1'b0);
    putDibit(2'b01, 1'b1, 1'b0); putDibit(2'b01, 1'b1, 1'b0);
    putDibit(2'b01, 1'b1, 1'b0); putDibit(2'b11, 1'b1, 1'b0);
    for (int i = 0; i < nNib; i++) begin
      nib = 4'($urandom);
      putDibit(nib[1:0], i < nNib - tail, i == errIdx);
      if (i == nNib - tail) begin
        check(miiCrs == 1'b0, "R8 carrier sense drop at first low", miiCrs, 0);
        check(obsQ.size() < nNib * rep, "R8 drop precedes final nibbles", obsQ.size(), nNib * rep);
      end
      putDibit(nib[3:2], 1'b1, 1'b0);
      repeat (rep) expQ.push_back({i == errIdx, nib});
    end
    putDibit(2'b00, 1'b0, 1'b0);
    if (tail == 0) begin
      check(miiCrs == 1'b0, "R8 carrier sense drop at first low", miiCrs, 0);
      check(obsQ.size() < nNib * rep, "R8 drop precedes final nibbles", obsQ.size(), nNib * rep);
    end
    putDibit(2'b00, 1'b0, 1'b0);
    repeat (40 * rep) @(negedge refClk);
    check(obsQ.size() == expQ.size(), "R9 delivered nibble count", obsQ.size(), expQ.size());
    if (!rate100) check(obsQ.size() == nNib * 10, "R4 ten MII clocks per nibble", obsQ.size(), nNib * 10);
    bad = -1;
    for (int i = 0; i < obsQ.size() && i < expQ.size(); i++)
      if (bad < 0 && obsQ[i] != expQ[i]) bad = i;
    check(bad < 0, "R2 R3 nibble stream content", bad >= 0 ? int'(obsQ[bad]) : 0,
          bad >= 0 ? int'(expQ[bad]) : 0);
    check(countErr(1) == countErr(0), "R6 flagged error nibbles", countErr(1), countErr(0));
    check(dvRises == 1, "R7 single data-valid run", dvRises, 1);
    check(fcCycles == 0, "R5 no false code on good frame", fcCycles, 0);
  endtask

  task automatic falseCarrier(input int nBad);
    clearObs();
    repeat (nBad) putDibit(2'b10, 1'b1, 1'b0);
    repeat (3) putDibit(2'b00, 1'b0, 1'b0);
    repeat (40 * rep) @(negedge refClk);
    check(fcCycles == rep, "R5 false carrier code slot", fcCycles, rep);
    check(obsQ.size() == 0, "R5 no data valid on false carrier", obsQ.size(), 0);
  endtask

  task automatic abortPreamble();
    clearObs();
    repeat (3) putDibit(2'b01, 1'b1, 1'b0);
    repeat (2) putDibit(2'b00, 1'b0, 1'b0);
    repeat (40 * rep) @(negedge refClk);
    check(obsQ.size() == 0, "R2 no output without delimiter", obsQ.size(), 0);
    check(fcCycles == 0 && miiCrs == 1'b0, "R2 aborted preamble is silent", fcCycles, 0);
  endtask

  initial begin
    repeat (400000) @(posedge refClk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge refClk);
    check(miiRxDv == 0 && miiRxErr == 0 && miiRxd == 0 && miiCrs == 0,
          "R1 outputs low in reset", {miiRxDv, miiRxErr, miiRxd, miiCrs}, 0);
    rstN = 1'b1;
    repeat (6) @(negedge refClk);
    check(miiRxDv == 0 && miiRxErr == 0 && miiRxd == 0 && miiCrs == 0,
          "R1 outputs low after reset", {miiRxDv, miiRxErr, miiRxd, miiCrs}, 0);
    sendFrame(3, 4, 0, -1, 1'b0);
    sendFrame(5, 6, 2, 1, 1'b0);
    sendFrame(2, 5, 1, 4, 1'b1);
    falseCarrier(2);
    falseCarrier(5);
    abortPreamble();
    for (int k = 0; k < 6; k++)
      sendFrame(int'($urandom_range(1, 8)), int'($urandom_range(2, 12)),
                int'($urandom_range(0, 2)), int'($urandom_range(0, 12)) - 1, 1'b0);
    rate100 = 1'b0; rep = 10;
    repeat (30) @(negedge refClk);
    sendFrame(2, 4, 1, 2, 1'b0);
    sendFrame(3, 3, 0, -1, 1'b0);
    falseCarrier(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule